// File: doc/BRIEF.md
# In-Band Pause/Resume Transmit Gate

This block sits on two paths of a serial port. On the receive side it stands between the word receiver and the receive FIFO. It decides, word by word, whether a received word is written into the FIFO. On the transmit side it stands between the transmit FIFO and the serializer. It decides whether the serializer may begin the next word.

Software loads two code values. One is a pause code and one is a resume code. When automatic flow control is switched on, every clean received word is compared with both codes. A pause word halts the local transmitter and a resume word releases it. Either way the control word is removed from the receive stream. Nothing else is signalled: the block has no interrupt. Received words that arrive while the transmitter is halted are still written normally.

Software is expected to hold the transmitter disabled with `tx_off` while it switches the feature on. The gate only stops the start of a word. A word the serializer has already begun is left to finish.

Top module: `xon_tx_gate`

## Requirements
- R1: After reset, `fifo_wr` is 0, the transmitter is not halted, and `tx_permit` is 1 whenever `tx_off` is 0.
- R2: With `flow_en` at 0, no comparison is made. Every word presented with `rx_valid` produces `fifo_wr` = 1 on the following cycle, with `fifo_data` and `fifo_err` equal to the received data and error flag.
- R3: With `flow_en` at 1, an error-free valid word equal to `pause_code` is not written. From the next cycle, `tx_permit` is 0 until the halt is released.
- R4: With `flow_en` at 1, an error-free valid word equal to `resume_code` (and not to `pause_code`) is not written. From the next cycle, `tx_permit` returns to 1 (given `tx_off` = 0).
- R5: While the transmitter is halted, valid words that are not control codes are still written to the FIFO on the following cycle.
- R6: A word received with `rx_err` = 1 is never treated as a control code. It is written to the FIFO with `fifo_err` = 1, and the halt state is unchanged.
- R7: `tx_start` is 1 exactly when `tx_req` and `tx_permit` are both 1, in the same cycle. Halting blocks only the start of the next word.
- R8: Driving `flow_en` to 0 clears the halt state on the next clock edge, so `tx_permit` rises from the next cycle when `tx_off` is 0. Reset also clears the halt state.
- R9: While `tx_off` is 1, `tx_permit` and `tx_start` are 0.
- R10: When `pause_code` equals `resume_code`, a matching word counts as a pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_data | input | 8 | Received word |
| rx_err | input | 1 | Received word had a framing or parity error |
| flow_en | input | 1 | Automatic transmit flow control enabled |
| pause_code | input | 8 | Code that halts the transmitter |
| resume_code | input | 8 | Code that releases the transmitter |
| tx_off | input | 1 | Software transmitter disable |
| tx_req | input | 1 | Serializer is idle and a word waits in the transmit FIFO |
| fifo_wr | output | 1 | Write strobe to the receive FIFO, one cycle after the word |
| fifo_data | output | 8 | Word written to the receive FIFO |
| fifo_err | output | 1 | Error flag written with the word |
| tx_permit | output | 1 | Transmitter may begin a new word |
| tx_start | output | 1 | Start the next transmit word now |

## Verification
The hardest state to reach from the ports is a halted transmitter that meets a corrupted control word. Reaching it needs a clean pause word first, then a resume code carrying `rx_err`. The bench must then show both that the word was written and that the halt survived. The vector table chains these words so that each entry starts from the halt state the earlier entries left behind. Directed steps follow for the remaining cases:
- dropping `flow_en` while halted, with no word received;
- a reset in the halted state;
- identical pause and resume codes;
- `tx_off` overriding the gate.

// File: rtl/xgate_pkg.sv
package xgate_pkg;

    parameter int WORD_W = 8;

    typedef enum logic [1:0] {
        CTL_NONE   = 2'd0,
        CTL_PAUSE  = 2'd1,
        CTL_RESUME = 2'd2
    } ctl_kind_t;

    typedef struct packed {
        logic              err;
        logic [WORD_W-1:0] data;
    } rx_word_t;

    // Pause takes priority when both codes match the same word.
    function automatic ctl_kind_t classify(
        input rx_word_t          w,
        input logic              en,
        input logic [WORD_W-1:0] pause_c,
        input logic [WORD_W-1:0] resume_c
    );
        if (!en || w.err)            return CTL_NONE;
        else if (w.data == pause_c)  return CTL_PAUSE;
        else if (w.data == resume_c) return CTL_RESUME;
        else                         return CTL_NONE;
    endfunction

endpackage

// File: rtl/xgate_classify.sv
module xgate_classify
    import xgate_pkg::*;
(
    input  logic              valid,
    input  rx_word_t          word,
    input  logic              en,
    input  logic [WORD_W-1:0] pause_c,
    input  logic [WORD_W-1:0] resume_c,
    output ctl_kind_t         kind
);
    always_comb begin
        if (valid) kind = classify(word, en, pause_c, resume_c);
        else       kind = CTL_NONE;
    end
endmodule

// File: rtl/xgate_rx_pass.sv
module xgate_rx_pass
    import xgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  rx_word_t  word,
    input  ctl_kind_t kind,
    output logic      wr,
    output rx_word_t  wr_word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wr      <= 1'b0;
            wr_word <= '0;
        end else begin
            wr <= valid && (kind == CTL_NONE);
            if (valid) wr_word <= word;
        end
    end
endmodule

// File: rtl/xgate_hold.sv
module xgate_hold
    import xgate_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  ctl_kind_t kind,
    output logic      halted
);
    always_ff @(posedge clk) begin
        if (rst || !en)               halted <= 1'b0;
        else if (kind == CTL_PAUSE)   halted <= 1'b1;
        else if (kind == CTL_RESUME)  halted <= 1'b0;
    end
endmodule

// File: rtl/xon_tx_gate.sv
module xon_tx_gate
    import xgate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] rx_data,
    input  logic              rx_err,
    input  logic              flow_en,
    input  logic [WORD_W-1:0] pause_code,
    input  logic [WORD_W-1:0] resume_code,
    input  logic              tx_off,
    input  logic              tx_req,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              fifo_err,
    output logic              tx_permit,
    output logic              tx_start
);
    rx_word_t  in_word;
    rx_word_t  out_word;
    ctl_kind_t kind;
    logic      halted;

    assign in_word = '{err: rx_err, data: rx_data};

    xgate_classify u_cls (
        .valid    (rx_valid),
        .word     (in_word),
        .en       (flow_en),
        .pause_c  (pause_code),
        .resume_c (resume_code),
        .kind     (kind)
    );

    xgate_rx_pass u_pass (
        .clk     (clk),
        .rst     (rst),
        .valid   (rx_valid),
        .word    (in_word),
        .kind    (kind),
        .wr      (fifo_wr),
        .wr_word (out_word)
    );

    xgate_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .en     (flow_en),
        .kind   (kind),
        .halted (halted)
    );

    assign fifo_data = out_word.data;
    assign fifo_err  = out_word.err;
    assign tx_permit = !halted && !tx_off;
    assign tx_start  = tx_req && tx_permit;
endmodule

// File: rtl/xon_tx_gate_chk.sv
module xon_tx_gate_chk
    import xgate_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic [WORD_W-1:0] rx_data,
    input logic              rx_err,
    input logic              flow_en,
    input logic [WORD_W-1:0] pause_code,
    input logic [WORD_W-1:0] resume_code,
    input logic              tx_off,
    input logic              tx_req,
    input logic              fifo_wr,
    input logic [WORD_W-1:0] fifo_data,
    input logic              fifo_err,
    input logic              tx_permit,
    input logic              tx_start,
    input logic              halted
);
    a_r2_pass_when_off: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !flow_en) |=> (fifo_wr && fifo_data == $past(rx_data)));

    a_r3_pause_halts: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && flow_en && !rx_err && rx_data == pause_code) |=> (halted && !fifo_wr));

    a_r4_resume_frees: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && flow_en && !rx_err && rx_data == resume_code && rx_data != pause_code)
        |=> (!halted && !fifo_wr));

    a_r6_err_written: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_err) |=> (fifo_wr && fifo_err && halted == $past(halted)));

    a_r7_start_gated: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (tx_req && tx_permit));

    a_r8_disable_clears: assert property (@(posedge clk) disable iff (rst)
        !flow_en |=> !halted);

    a_r9_off_blocks: assert property (@(posedge clk) disable iff (rst)
        tx_off |-> (!tx_permit && !tx_start));
endmodule

bind xon_tx_gate xon_tx_gate_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .rx_err      (rx_err),
    .flow_en     (flow_en),
    .pause_code  (pause_code),
    .resume_code (resume_code),
    .tx_off      (tx_off),
    .tx_req      (tx_req),
    .fifo_wr     (fifo_wr),
    .fifo_data   (fifo_data),
    .fifo_err    (fifo_err),
    .tx_permit   (tx_permit),
    .tx_start    (tx_start),
    .halted      (halted)
);

// File: tb/test_xon_tx_gate.sv
module test_xon_tx_gate;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;
    localparam logic [7:0] PAUSE  = 8'h13;
    localparam logic [7:0] RESUME = 8'h11;

    // Entry layout: {flow_en, rx_err, expected fifo_wr, expected tx_permit, data}
    localparam logic [11:0] VEC [0:NVEC-1] = '{
        {4'b1011, 8'h41},  // R5 plain word, running
        {4'b1000, 8'h13},  // R3 pause dropped, halts
        {4'b1010, 8'h42},  // R5 word written while halted
        {4'b1110, 8'h11},  // R6 corrupted resume written, still halted
        {4'b1000, 8'h13},  // R3 repeated pause
        {4'b1001, 8'h11},  // R4 resume dropped, released
        {4'b1111, 8'h13},  // R6 corrupted pause written, no halt
        {4'b0011, 8'h13},  // R2 disabled: pause passes
        {4'b0011, 8'h11},  // R2 disabled: resume passes
        {4'b1001, 8'h11},  // R4 resume while running dropped
        {4'b1011, 8'h00}   // R5 plain word
    };

    logic clk = 1'b0;
    logic rst;
    logic rx_valid, rx_err, flow_en, tx_off, tx_req;
    logic [7:0] rx_data, pause_code, resume_code;
    logic fifo_wr, fifo_err, tx_permit, tx_start;
    logic [7:0] fifo_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xon_tx_gate i_xon_tx_gate (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .flow_en(flow_en), .pause_code(pause_code), .resume_code(resume_code),
        .tx_off(tx_off), .tx_req(tx_req), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .fifo_err(fifo_err), .tx_permit(tx_permit), .tx_start(tx_start)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one word at a negedge, then return at the following negedge with valid dropped.
    task automatic send(input logic en, input logic err, input logic [7:0] d);
        flow_en  = en;
        rx_err   = err;
        rx_data  = d;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_err   = 1'b0;
    endtask

    task automatic finish_run;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; rx_valid = 0; rx_err = 0; rx_data = 0; flow_en = 0;
        tx_off = 0; tx_req = 0; pause_code = PAUSE; resume_code = RESUME;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 fifo_wr", fifo_wr, 0);
        chk("R1 tx_permit", tx_permit, 1);

        for (int i = 0; i < NVEC; i++) begin
            send(VEC[i][11], VEC[i][10], VEC[i][7:0]);
            chk("R2-R6 vec fifo_wr", fifo_wr, VEC[i][9]);
            if (VEC[i][9]) begin
                chk("R2 vec fifo_data", fifo_data, VEC[i][7:0]);
                chk("R6 vec fifo_err", fifo_err, VEC[i][10]);
            end
            chk("R3/R4 vec tx_permit", tx_permit, VEC[i][8]);
        end

        // R7: start follows request and permit
        tx_req = 1'b1;
        #1 chk("R7 start while running", tx_start, 1);
        send(1'b1, 1'b0, PAUSE);
        chk("R7 start blocked when halted", tx_start, 0);
        tx_req = 1'b0;
        #1 chk("R7 no start without request", tx_start, 0);

        // R8: dropping flow_en clears the halt with no word received
        flow_en = 1'b0;
        @(negedge clk);
        chk("R8 disable clears halt", tx_permit, 1);

        // R8: reset clears the halt
        send(1'b1, 1'b0, PAUSE);
        chk("R8 halted before reset", tx_permit, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset clears halt", tx_permit, 1);

        // R9: software disable wins
        tx_off = 1'b1; tx_req = 1'b1;
        #1 chk("R9 permit off", tx_permit, 0);
        chk("R9 start off", tx_start, 0);
        tx_off = 1'b0; tx_req = 1'b0;

        // R10: equal codes act as pause
        resume_code = PAUSE;
        send(1'b1, 1'b0, PAUSE);
        chk("R10 equal codes dropped", fifo_wr, 0);
        chk("R10 equal codes halt", tx_permit, 0);
        resume_code = RESUME;
        send(1'b1, 1'b0, RESUME);
        chk("R4 resume after R10", tx_permit, 1);

        done = 1;
        finish_run();
    end
endmodule